// File: doc/BRIEF.md
# Select-Coded Narrow Unsigned Multiplier

This block forms the unsigned product of two very narrow operands without an AND-array of partial products. The multiplicand acts as the select code of a small multiplexer. Every data leg of that multiplexer holds a fixed combination of shifted copies of the multiplier operand, added together. The selected leg is therefore the product itself. The leg values depend only on the multiplier operand, so they can be formed in parallel with the arrival of the select code.

The block is purely combinational. One enumerated parameter picks among three size variants:
- A 2-bit multiplicand with a 2-bit multiplier, using a 4-way mux.
- A 2-bit multiplicand with a 3-bit multiplier, using a 4-way mux.
- A 3-bit multiplicand with a 3-bit multiplier, using an 8-way mux.

Larger multipliers can tile these cells and sum the tiles.

Top module: `mux_mul_core`

## Requirements
- R1: The variant sets the port widths. With `MUL_2X2` the multiplicand, multiplier and product are 2, 2 and 4 bits wide. With `MUL_3X2` they are 2, 3 and 5 bits. With `MUL_3X3` they are 3, 3 and 6 bits.
- R2: A multiplicand (select code) of zero gives a product of zero, whatever the multiplier is.
- R3: A select code of 1 gives the multiplier unchanged, zero-extended to the product width.
- R4: A select code of 2 gives the multiplier shifted left by one. A select code of 4 (3-bit select only) gives it shifted left by two.
- R5: A select code of 3 gives the multiplier plus its one-place shift. A select code of 5 gives the multiplier plus its two-place shift.
- R6: A select code of 6 gives the one-place shift plus the two-place shift. A select code of 7 gives the sum of the unshifted, one-place and two-place copies.
- R7: No carry is lost. The all-ones operand pair gives 9, 21 and 49 for the three variants, in the order listed in R1.
- R8: The output follows an input change within the same time step, with no clock and no stored state.
- R9: A multiplier operand of zero gives a product of zero for every select code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | 2 or 3 (per variant) | Multiplicand, used as the mux select code |
| mplier_i | input | 2 or 3 (per variant) | Multiplier operand feeding every mux leg |
| prod_o | output | 4, 5 or 6 (per variant) | Full-width unsigned product |

## Verification
Every operand pair of every variant is applied and compared with an arithmetic product. Because of this sweep, each select code is exercised against every multiplier value, and a wrong shift or a missing addend in any single leg shows up as a mismatch on that code alone. Directed all-ones and all-zero pairs separate carry loss at the top bit from a bad leg 0 or a missing zero-extension. A randomized pass with a fixed seed then changes both operands together between samples, and a mid-period change with no clock edge in between shows that the output has no hidden state.

// File: rtl/mux_mul_pkg.sv
// Package: shared variant type and width helpers for the select-coded multiplier.
// Assumes only the three listed variants are ever requested.
package mux_mul_pkg;

    typedef enum logic [1:0] {
        MUL_2X2 = 2'd0,
        MUL_3X2 = 2'd1,
        MUL_3X3 = 2'd2
    } mul_variant_e;

    // Width of the select (multiplicand) operand for a variant.
    function automatic int sel_width(input mul_variant_e v);
        return (v == MUL_3X3) ? 3 : 2;
    endfunction

    // Width of the multiplier operand for a variant.
    function automatic int opd_width(input mul_variant_e v);
        return (v == MUL_2X2) ? 2 : 3;
    endfunction

    // Full product width: sum of both operand widths.
    function automatic int prod_width(input mul_variant_e v);
        return sel_width(v) + opd_width(v);
    endfunction

endpackage

// File: rtl/mux_mul_legs.sv
// Module: builds every mux data leg from the multiplier operand.
// Leg k is the sum of (operand << i) over each set bit i of k.
// Assumes P_W >= OPD_W + SEL_W, so that no shifted copy or sum loses a carry.
module mux_mul_legs #(
    parameter int SEL_W = 2,
    parameter int OPD_W = 2,
    parameter int P_W   = SEL_W + OPD_W,
    localparam int N_LEG = 1 << SEL_W
) (
    input  logic [OPD_W-1:0]            opd_i,
    output logic [N_LEG-1:0][P_W-1:0]   leg_o
);

    logic [P_W-1:0] opd_ext;

    // Widen the operand to the product width before any shift.
    always_comb opd_ext = {{(P_W-OPD_W){1'b0}}, opd_i};

    for (genvar k = 0; k < N_LEG; k++) begin : g_leg
        logic [SEL_W-1:0][P_W-1:0] term;

        for (genvar i = 0; i < SEL_W; i++) begin : g_term
            localparam bit USE_TERM = ((k >> i) & 1) == 1;
            if (USE_TERM) begin : g_on
                // Shifted copy that this leg includes.
                always_comb term[i] = opd_ext << i;
            end else begin : g_off
                // Shifted copy that this leg leaves out.
                always_comb term[i] = '0;
            end
        end

        // Sum the selected shifted copies into the leg value.
        always_comb begin
            leg_o[k] = '0;
            for (int i = 0; i < SEL_W; i++) begin
                leg_o[k] = leg_o[k] + term[i];
            end
        end
    end

endmodule

// File: rtl/mux_mul_sel.sv
// Module: select-coded mux that returns one precomputed leg.
// Assumes leg 0 carries zero; the assertion below guards that contract.
module mux_mul_sel #(
    parameter int SEL_W = 2,
    parameter int P_W   = 4,
    localparam int N_LEG = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]            sel_i,
    input  logic [N_LEG-1:0][P_W-1:0]   leg_i,
    output logic [P_W-1:0]              y_o
);

    // Pass the leg addressed by the select code.
    always_comb y_o = leg_i[sel_i];

    // Zero select must yield zero from the leg builder (R2).
    always_comb begin
        p_zero_sel_r2: assert (!(sel_i == '0) || (y_o == '0))
            else $error("zero select gave nonzero output");
    end

endmodule

// File: rtl/mux_mul_core.sv
// Module: top of the select-coded narrow unsigned multiplier.
// The multiplicand drives the mux select; the legs come from the multiplier.
// Purely combinational; widths follow the VARIANT parameter.
module mux_mul_core
    import mux_mul_pkg::*;
#(
    parameter mul_variant_e VARIANT = MUL_3X3,
    localparam int SEL_W = sel_width(VARIANT),
    localparam int OPD_W = opd_width(VARIANT),
    localparam int P_W   = prod_width(VARIANT),
    localparam int N_LEG = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] mcand_i,
    input  logic [OPD_W-1:0] mplier_i,
    output logic [P_W-1:0]   prod_o
);

    logic [N_LEG-1:0][P_W-1:0] legs;

    mux_mul_legs #(
        .SEL_W (SEL_W),
        .OPD_W (OPD_W),
        .P_W   (P_W)
    ) u_legs (
        .opd_i (mplier_i),
        .leg_o (legs)
    );

    mux_mul_sel #(
        .SEL_W (SEL_W),
        .P_W   (P_W)
    ) u_sel (
        .sel_i (mcand_i),
        .leg_i (legs),
        .y_o   (prod_o)
    );

    // Port-level checks of the product against its operands.
    always_comb begin
        p_zero_mcand_r2: assert (!(mcand_i == '0) || (prod_o == '0))
            else $error("zero multiplicand gave nonzero product");
        p_unity_r3: assert (!(mcand_i == SEL_W'(1)) || (prod_o == P_W'(mplier_i)))
            else $error("unit multiplicand did not pass multiplier");
        p_zero_mplier_r9: assert (!(mplier_i == '0) || (prod_o == '0))
            else $error("zero multiplier gave nonzero product");
        p_lsb_r7: assert (prod_o[0] == (mcand_i[0] & mplier_i[0]))
            else $error("product lsb wrong");
    end

endmodule

// File: tb/mux_mul_core_bench.sv
// Bench: exhaustive plus seeded random checks for all three variants.
module mux_mul_core_bench;
    import mux_mul_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    logic [2:0] a33, b33;
    logic [5:0] p33;
    logic [1:0] a32;
    logic [2:0] b32;
    logic [4:0] p32;
    logic [1:0] a22, b22;
    logic [3:0] p22;

    mux_mul_core #(.VARIANT(MUL_3X3)) u_mux_mul_core (
        .mcand_i (a33), .mplier_i (b33), .prod_o (p33));
    mux_mul_core #(.VARIANT(MUL_3X2)) u_mux_mul_core_3x2 (
        .mcand_i (a32), .mplier_i (b32), .prod_o (p32));
    mux_mul_core #(.VARIANT(MUL_2X2)) u_mux_mul_core_2x2 (
        .mcand_i (a22), .mplier_i (b22), .prod_o (p22));

    function automatic int ref_mul(input int a, input int b);
        return a * b;
    endfunction

    // Requirement tag for an operand pair, by select code.
    function automatic string tag_of(input int a, input int b);
        if (a == 0) return "R2";
        if (b == 0) return "R9";
        case (a)
            1:       return "R3";
            2, 4:    return "R4";
            3, 5:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // Apply one pair to all variants, then sample at the falling edge.
    task automatic apply(input int a, input int b);
        @(posedge clk);
        a33 = 3'(a); b33 = 3'(b);
        a32 = 2'(a); b32 = 3'(b);
        a22 = 2'(a); b22 = 2'(b);
        @(negedge clk);
    endtask

    initial begin
        a33 = '0; b33 = '0; a32 = '0; b32 = '0; a22 = '0; b22 = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: zero operands give zero products (R2).
        check("R2", int'(p33), 0);
        check("R2", int'(p32), 0);
        check("R2", int'(p22), 0);
        // R1: port widths per variant.
        check("R1", $bits(p22), 4);
        check("R1", $bits(p32), 5);
        check("R1", $bits(p33), 6);
        check("R1", $bits(b32), 3);
        // Exhaustive sweep of every select code and multiplier value.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                apply(a, b);
                check(tag_of(a, b), int'(p33), ref_mul(a, b));
                if (a < 4) check(tag_of(a, b), int'(p32), ref_mul(a, b));
                if (a < 4 && b < 4) check(tag_of(a, b), int'(p22), ref_mul(a, b));
            end
        end
        // R7: all-ones operands, carry must reach the top bit.
        apply(7, 7);
        check("R7", int'(p33), 49);
        check("R7", int'(p32), 21);
        check("R7", int'(p22), 9);
        // R8: change inputs mid-period with no clock edge in between.
        a33 = 3'd6; b33 = 3'd5;
        #1;
        check("R8", int'(p33), 30);
        a33 = 3'd3;
        #1;
        check("R8", int'(p33), 15);
        // Seeded random pass.
        void'($urandom(32'h5eed_c0de));
        for (int n = 0; n < 300; n++) begin
            int ra, rb;
            ra = int'($urandom % 8);
            rb = int'($urandom % 8);
            apply(ra, rb);
            check(tag_of(ra, rb), int'(p33), ref_mul(ra, rb));
            check(tag_of(ra % 4, rb), int'(p32), ref_mul(ra % 4, rb));
            check(tag_of(ra % 4, rb % 4), int'(p22), ref_mul(ra % 4, rb % 4));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule